// File: doc/BRIEF.md
# Lane-Partitioned Wide Vector Adder

This block adds or subtracts two 256-bit operands on one carry chain that can be cut at lane boundaries chosen at run time. With the chain cut, the same datapath does thirty-two 8-bit, sixteen 16-bit, eight 32-bit or four 64-bit operations in parallel. With the chain left whole, it does a single 256-bit operation. Subtraction adds the inverted B operand and forces a carry-in of one into every lane.

In full-width mode the block keeps its own carry register, separate from any scalar flag. A "with carry" control takes the carry-in from that register, and every accepted full-width operation writes its carry-out back. Software can therefore chain 256-bit words into larger multi-precision sums or differences. Results, per-lane carry-outs and a valid strobe appear one clock after an operation is accepted.

Top module: `wide_lane_adder`

## Requirements
- R1: `lane_sel` sets the lane width: 0 gives 8-bit lanes, 1 gives 16-bit lanes, 2 gives 32-bit lanes, 3 gives 64-bit lanes and 4 gives one 256-bit lane. Codes 5, 6 and 7 behave like code 0.
- R2: In the 8, 16, 32 and 64-bit modes, lane i covers bits [i*W +: W]. Each lane's sum is A plus B modulo 2^W, and no carry crosses from one lane into the next.
- R3: With `sub` high, each lane produces A minus B modulo its width, computed as A + ~B + 1. The lane's carry-out is 1 when no borrow occurs.
- R4: In 256-bit mode the carry-in is the carry register when `use_carry` is high. Otherwise it is 0 for an add and 1 for a subtract. `use_carry` has no effect in the narrower modes.
- R5: `lane_cout` bit i is the carry out of the top bit of lane i. Bits at or above the lane count read 0, and in 256-bit mode only bit 0 is used.
- R6: `carry_flag` is the carry register. Only an accepted 256-bit operation loads it, with that operation's carry-out. Every other cycle it holds its value.
- R7: `out_valid` equals `in_valid` delayed by one clock. `result` and `lane_cout` update one clock after an accepted operation and hold while `in_valid` is low.
- R8: While `rst` is high, `out_valid`, `result`, `lane_cout` and `carry_flag` are all cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs |
| op_a | input | 256 | Operand A |
| op_b | input | 256 | Operand B |
| lane_sel | input | 3 | Lane width code |
| sub | input | 1 | 1 selects subtraction |
| use_carry | input | 1 | Take the full-width carry-in from the carry register |
| out_valid | output | 1 | Result registers hold a fresh operation |
| result | output | 256 | Registered sum or difference |
| lane_cout | output | 32 | Registered per-lane carry-outs |
| carry_flag | output | 1 | Full-width carry register |

## Verification
Every output is due exactly one clock after the operation that causes it. `result`, `lane_cout` and `out_valid` come from the single output register, and `carry_flag` is written at the same edge. The bench applies inputs at a falling edge. At the next falling edge it compares the outputs against a behavioural model that it advanced when those inputs were applied. Idle cycles are included, so the model predicts held values and an unchanged carry register, and the chained cases depend on the model's own carry state from the previous operation.

// File: rtl/lane_adder_pkg.sv
package lane_adder_pkg;

    typedef enum logic [2:0] {
        LANE_8    = 3'd0,
        LANE_16   = 3'd1,
        LANE_32   = 3'd2,
        LANE_64   = 3'd3,
        LANE_FULL = 3'd4
    } lane_sel_e;

    typedef struct packed {
        logic [2:0] sel;
        logic       sub;
        logic       use_c;
    } op_ctrl_t;

    // Number of byte chunks that form one lane for a given select code.
    function automatic int lane_chunks(input logic [2:0] sel, input int nchunk);
        case (sel)
            LANE_16:   return 2;
            LANE_32:   return 4;
            LANE_64:   return 8;
            LANE_FULL: return nchunk;
            default:   return 1;
        endcase
    endfunction

endpackage

// File: rtl/chunk_add.sv
module chunk_add #(
    parameter int CHUNK_W = 8
) (
    input  logic [CHUNK_W-1:0] a,
    input  logic [CHUNK_W-1:0] b,
    input  logic               inv_b,
    input  logic               cin,
    output logic [CHUNK_W-1:0] sum,
    output logic               cout
);
    logic [CHUNK_W-1:0] b_eff;

    always_comb begin
        b_eff       = b ^ {CHUNK_W{inv_b}};
        {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{CHUNK_W{1'b0}}, cin};
    end
endmodule

// File: rtl/lane_boundary_dec.sv
module lane_boundary_dec #(
    parameter int NCHUNK = 32
) (
    input  logic [2:0]        lane_sel,
    output logic [NCHUNK-1:0] cut
);
    import lane_adder_pkg::*;

    always_comb begin
        int n;
        n = lane_chunks(lane_sel, NCHUNK);
        for (int k = 0; k < NCHUNK; k++) begin
            cut[k] = ((k & (n - 1)) == 0);
        end
    end
endmodule

// File: rtl/lane_cout_pack.sv
module lane_cout_pack #(
    parameter int NCHUNK = 32
) (
    input  logic [2:0]        lane_sel,
    input  logic [NCHUNK-1:0] chunk_co,
    output logic [NCHUNK-1:0] lane_co
);
    import lane_adder_pkg::*;
    localparam int IDX_W = $clog2(NCHUNK);

    always_comb begin
        int n;
        int idx;
        n       = lane_chunks(lane_sel, NCHUNK);
        lane_co = '0;
        for (int i = 0; i < NCHUNK; i++) begin
            if (i * n < NCHUNK) begin
                idx        = i * n + n - 1;
                lane_co[i] = chunk_co[IDX_W'(idx)];
            end
        end
    end
endmodule

// File: rtl/wide_lane_adder.sv
module wide_lane_adder #(
    parameter int DATA_W  = 256,
    parameter int CHUNK_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic [DATA_W-1:0]            op_a,
    input  logic [DATA_W-1:0]            op_b,
    input  logic [2:0]                   lane_sel,
    input  logic                         sub,
    input  logic                         use_carry,
    output logic                         out_valid,
    output logic [DATA_W-1:0]            result,
    output logic [DATA_W/CHUNK_W-1:0]    lane_cout,
    output logic                         carry_flag
);
    import lane_adder_pkg::*;
    localparam int NCHUNK = DATA_W / CHUNK_W;

    op_ctrl_t           ctrl;
    logic               full_mode;
    logic               lane_cin;
    logic [NCHUNK-1:0]  cut;
    logic [NCHUNK-1:0]  chunk_ci;
    logic [NCHUNK-1:0]  chunk_co;
    logic [NCHUNK-1:0]  lane_co;
    logic [DATA_W-1:0]  sum;

    always_comb begin
        ctrl.sel   = lane_sel;
        ctrl.sub   = sub;
        ctrl.use_c = use_carry;
        full_mode  = (ctrl.sel == LANE_FULL);
        lane_cin   = (full_mode && ctrl.use_c) ? carry_flag : ctrl.sub;
    end

    lane_boundary_dec #(.NCHUNK(NCHUNK)) u_cut (
        .lane_sel (ctrl.sel),
        .cut      (cut)
    );

    for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
        if (g == 0) begin : g_first
            assign chunk_ci[g] = lane_cin;
        end else begin : g_rest
            assign chunk_ci[g] = cut[g] ? lane_cin : chunk_co[g-1];
        end

        chunk_add #(.CHUNK_W(CHUNK_W)) u_add (
            .a     (op_a[g*CHUNK_W +: CHUNK_W]),
            .b     (op_b[g*CHUNK_W +: CHUNK_W]),
            .inv_b (ctrl.sub),
            .cin   (chunk_ci[g]),
            .sum   (sum[g*CHUNK_W +: CHUNK_W]),
            .cout  (chunk_co[g])
        );
    end

    lane_cout_pack #(.NCHUNK(NCHUNK)) u_pack (
        .lane_sel (ctrl.sel),
        .chunk_co (chunk_co),
        .lane_co  (lane_co)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            result     <= '0;
            lane_cout  <= '0;
            carry_flag <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= sum;
                lane_cout <= lane_co;
                if (full_mode) begin
                    carry_flag <= chunk_co[NCHUNK-1];
                end
            end
        end
    end
endmodule

// File: rtl/wide_lane_adder_chk.sv
module wide_lane_adder_chk #(
    parameter int DATA_W  = 256,
    parameter int CHUNK_W = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      in_valid,
    input logic [DATA_W-1:0]         op_a,
    input logic [DATA_W-1:0]         op_b,
    input logic [2:0]                lane_sel,
    input logic                      sub,
    input logic                      use_carry,
    input logic                      out_valid,
    input logic [DATA_W-1:0]         result,
    input logic [DATA_W/CHUNK_W-1:0] lane_cout,
    input logic                      carry_flag
);
    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R7
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result) && $stable(lane_cout));

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && lane_sel == 3'd4) |=> $stable(carry_flag));

    // R5
    cout_unused_32_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lane_sel == 3'd2) |=> (lane_cout[DATA_W/CHUNK_W-1:8] == '0));

    // R5
    cout_unused_full_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lane_sel == 3'd4) |=> (lane_cout[DATA_W/CHUNK_W-1:1] == '0));

    // R2
    low_byte_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lane_sel == 3'd0 && !sub) |=>
        (result[7:0] == $past(op_a[7:0] + op_b[7:0])));

    // R4
    full_plain_add_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lane_sel == 3'd4 && !sub && !use_carry) |=>
        ({lane_cout[0], result} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)})));
endmodule

bind wide_lane_adder wide_lane_adder_chk #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) u_chk (.*);

// File: tb/wide_lane_adder_bench.sv
module wide_lane_adder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 256;
    localparam int NC = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] op_a = '0;
    logic [DW-1:0] op_b = '0;
    logic [2:0]    lane_sel = 3'd0;
    logic          sub = 1'b0;
    logic          use_carry = 1'b0;
    logic          out_valid;
    logic [DW-1:0] result;
    logic [NC-1:0] lane_cout;
    logic          carry_flag;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic          exp_valid = 1'b0;
    logic [DW-1:0] exp_res   = '0;
    logic [NC-1:0] exp_co    = '0;
    logic          exp_flag  = 1'b0;
    string         exp_tag   = "R8";

    always #(CLK_PERIOD/2) clk = ~clk;

    wide_lane_adder u_wide_lane_adder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .lane_sel(lane_sel), .sub(sub), .use_carry(use_carry),
        .out_valid(out_valid), .result(result), .lane_cout(lane_cout),
        .carry_flag(carry_flag)
    );

    task automatic check_bit(string tag, logic act, logic expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, act, expv);
        end
    endtask

    task automatic check_vec(string tag, logic [DW-1:0] act, logic [DW-1:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, expv);
        end
    endtask

    task automatic compare_all();
        check_bit("R7 out_valid", out_valid, exp_valid);
        check_vec(exp_tag, result, exp_res);
        check_vec("R5 lane_cout", {{(DW-NC){1'b0}}, lane_cout}, {{(DW-NC){1'b0}}, exp_co});
        check_bit("R6 carry_flag", carry_flag, exp_flag);
    endtask

    // Behavioural model of one accepted operation.
    task automatic model(input logic [DW-1:0] a, input logic [DW-1:0] b,
                         input logic [2:0] sel, input logic s, input logic uc);
        int w;
        int lanes;
        logic [DW:0] mask;
        logic [DW:0] la;
        logic [DW:0] lb;
        logic [DW:0] tot;
        logic [DW-1:0] bb;
        logic cin;
        case (sel)
            3'd1: w = 16;
            3'd2: w = 32;
            3'd3: w = 64;
            3'd4: w = 256;
            default: w = 8;
        endcase
        lanes = DW / w;
        mask  = ({{DW{1'b0}}, 1'b1} << w) - 1;
        bb    = s ? ~b : b;
        cin   = (w == DW && uc) ? exp_flag : s;
        exp_res = '0;
        exp_co  = '0;
        for (int i = 0; i < lanes; i++) begin
            la  = ({1'b0, a}  >> (i * w)) & mask;
            lb  = ({1'b0, bb} >> (i * w)) & mask;
            tot = la + lb + {{DW{1'b0}}, cin};
            exp_res = exp_res | DW'((tot & mask) << (i * w));
            exp_co[i] = tot[w];
        end
        if (w == DW) exp_flag = exp_co[0];
        if (sel > 3'd4) exp_tag = "R1 result";
        else if (w == DW) exp_tag = "R4 result";
        else if (s) exp_tag = "R3 result";
        else exp_tag = "R2 result";
    endtask

    task automatic step(input logic v, input logic [DW-1:0] a, input logic [DW-1:0] b,
                        input logic [2:0] sel, input logic s, input logic uc);
        @(negedge clk);
        compare_all();
        in_valid  = v;
        op_a      = a;
        op_b      = b;
        lane_sel  = sel;
        sub       = s;
        use_carry = uc;
        exp_valid = v;
        if (v) model(a, b, sel, s, uc);
        else exp_tag = "R7 held result";
    endtask

    function automatic logic [DW-1:0] rnd();
        logic [DW-1:0] r;
        for (int i = 0; i < DW / 32; i++) r[i*32 +: 32] = $urandom();
        return r;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] ones;
        logic [DW-1:0] byte1;
        ones  = '1;
        byte1 = {32{8'h01}};
        repeat (3) @(negedge clk);
        // R8: outputs cleared while reset is held
        compare_all();
        rst = 1'b0;

        // R2 / R1 lane modes: every lane wraps to zero with carry set
        step(1, ones, byte1, 3'd0, 0, 0);
        step(1, ones, {16{16'h0001}}, 3'd1, 0, 0);
        step(1, ones, {8{32'h1}}, 3'd2, 0, 1);
        step(1, ones, {4{64'h1}}, 3'd3, 0, 0);
        // R4 full-width wrap: carry out into the register
        step(1, ones, {{(DW-1){1'b0}}, 1'b1}, 3'd4, 0, 0);
        // R4 chained add uses the carry register (1)
        step(1, '0, '0, 3'd4, 0, 1);
        // R6 idle cycles with junk full-mode inputs leave the flag alone
        step(0, ones, ones, 3'd4, 0, 0);
        step(0, rnd(), rnd(), 3'd4, 1, 1);
        // R3 / R4 borrow chain
        step(1, '0, {{(DW-1){1'b0}}, 1'b1}, 3'd4, 1, 0);
        step(1, '0, '0, 3'd4, 1, 1);
        step(1, {{(DW-1){1'b0}}, 1'b1}, '0, 3'd4, 1, 1);
        // R3 lane subtracts
        step(1, '0, byte1, 3'd0, 1, 0);
        step(1, rnd(), rnd(), 3'd2, 1, 0);
        // R1 spare codes act as 8-bit lanes
        step(1, ones, byte1, 3'd5, 0, 0);
        step(1, rnd(), rnd(), 3'd6, 1, 0);
        step(1, rnd(), rnd(), 3'd7, 0, 1);
        // R4 use_carry ignored in lane modes after a carry-setting full op
        step(1, ones, ones, 3'd4, 0, 0);
        step(1, '0, '0, 3'd3, 0, 1);
        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            logic [2:0] sel;
            sel = 3'($urandom_range(0, 7));
            step(($urandom() % 4) != 0, rnd(), rnd(), sel, 1'($urandom()), 1'($urandom()));
        end
        step(0, '0, '0, 3'd0, 0, 0);
        step(0, '0, '0, 3'd0, 0, 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule